// File: doc/BRIEF.md
# Per-Processor Private Interrupt State Engine

This block keeps the per-processor state of 32 private interrupts: 16 software-generated interrupts (IDs 0 to 15) and 16 peripheral interrupts (IDs 16 to 31). For each interrupt it holds a group bit, an enable bit, a pending latch, an active bit and a trigger-mode bit. Software changes this state through a word-wide register port. Enable, pending and active each have a set-style address and a clear-style address. Peripheral lines arrive as 32 level inputs. Software-interrupt requests arrive on a separate request port.

Every register access carries a secure attribute. When security is enabled (`sec_disable` low), a non-secure access reaches only the bits of interrupts in Group 1. Bits of other interrupts read as zero and ignore writes. When `sec_disable` is high, the attribute does not filter any access. The trigger mode is packed two bits per interrupt into two configuration words. A non-secure software request is screened by a 2-bit access-level field for each software interrupt.

The block drives its pending, enable, active and group bitmaps straight from registers. Priority storage, arbitration and signalling to the processor lie outside this block.

Top module: `pirq_state_top`

## Requirements
- R1: After a synchronous active-high reset, the group, enable, pending, active, trigger-mode, group-modifier and access-level registers are all zero, and so is `reg_rdata`.
- R2: A set-style write ORs the masked write data into its bitmap. A clear-style write clears the masked bits. This holds for enable, pending and active.
- R3: With security enabled, a non-secure access uses the group register as its per-bit mask. Bits of Group 0 interrupts (group bit 0) read as zero and ignore writes. This applies to every bitmap and to the trigger-mode words.
- R4: With `sec_disable` high, a non-secure access is not filtered: every bit is readable and writable.
- R5: A read of the pending addresses returns the pending latch ORed with (`line_level` AND NOT trigger-mode), masked as in R3. `pend_o` shows the latch alone.
- R6: A 0-to-1 change of `line_level[i]` sets pending bit i only when trigger-mode bit i is 1 (edge). A line held high does not set the bit again after it has been cleared.
- R7: Configuration word A (address 7) covers interrupts 0 to 15. Word B (address 8) covers 16 to 31. Interrupt i sits at bit 2*(i mod 16)+1, and even bits read as zero. Writes to word A are ignored. Writes to word B update trigger-mode bits 16 to 31 under the R3 mask.
- R8: The group register reads as zero and ignores writes for a non-secure access while security is enabled.
- R9: The group-modifier and access-level registers are read and written only by a secure access while security is enabled. In every other case they read as zero and ignore writes.
- R10: A software request with ID n is rejected if `sgi_grp1` differs from group bit n. A non-secure request with security enabled must also have an access-level field (bits 2n+1:2n) of at least 1 for a Group 0 target, or at least 2 for a Group 1 target. An accepted request sets pending bit n.
- R11: `reg_rdata` carries the value of the addressed register one cycle after the read strobe and holds when there is no strobe. A write takes effect at the clock edge that samples it.
- R12: Address map: 0 group, 1 set-enable, 2 clear-enable, 3 set-pending, 4 clear-pending, 5 set-active, 6 clear-active, 7 word A, 8 word B, 9 group-modifier, 10 access-level. Both addresses of a set/clear pair read the same bitmap, and unlisted addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_secure | input | 1 | Access is secure |
| reg_rdata | output | 32 | Registered read data |
| sec_disable | input | 1 | Global security disable |
| line_level | input | 32 | Interrupt input levels |
| sgi_req | input | 1 | Software interrupt request strobe |
| sgi_id | input | 4 | Software interrupt ID |
| sgi_grp1 | input | 1 | Requested group (1 = Group 1) |
| sgi_ns | input | 1 | Request is non-secure |
| pend_o | output | 32 | Pending latch bitmap |
| enable_o | output | 32 | Enable bitmap |
| active_o | output | 32 | Active bitmap |
| group_o | output | 32 | Group bitmap |

## Verification
The hardest case to reach is a non-secure software request whose outcome depends on three things at once: the target's group bit, the requested group, and a 2-bit access-level field. Only a secure access can set that field, and only while security is enabled. The bench first uses secure writes to build a group pattern with one Group 0 software interrupt. It then loads access levels 0, 1 and 2 into different fields. Finally it sends non-secure and secure requests that fall on both sides of each threshold and one that has the wrong group. A second hard case is an edge line that stays high after its pending bit has been cleared. The bench holds the line across several cycles and checks that the latch stays clear.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned REG_AW = 4;

  localparam logic [REG_AW-1:0] A_GROUP  = 4'd0;
  localparam logic [REG_AW-1:0] A_EN_SET = 4'd1;
  localparam logic [REG_AW-1:0] A_EN_CLR = 4'd2;
  localparam logic [REG_AW-1:0] A_PD_SET = 4'd3;
  localparam logic [REG_AW-1:0] A_PD_CLR = 4'd4;
  localparam logic [REG_AW-1:0] A_AC_SET = 4'd5;
  localparam logic [REG_AW-1:0] A_AC_CLR = 4'd6;
  localparam logic [REG_AW-1:0] A_CFG_A  = 4'd7;
  localparam logic [REG_AW-1:0] A_CFG_B  = 4'd8;
  localparam logic [REG_AW-1:0] A_GRPMOD = 4'd9;
  localparam logic [REG_AW-1:0] A_NSACC  = 4'd10;

  typedef struct packed {
    logic grp_ok;
    logic priv_ok;
  } acc_rights_t;
endpackage

// File: rtl/pirq_access_filter.sv
module pirq_access_filter #(
  parameter int unsigned N = 32
) (
  input  logic                  secure,
  input  logic                  sec_disable,
  input  logic [N-1:0]          group,
  output logic [N-1:0]          mask,
  output pirq_pkg::acc_rights_t rights
);
  logic filtered;

  always_comb begin
    filtered       = !secure && !sec_disable;
    mask           = filtered ? group : {N{1'b1}};
    rights.grp_ok  = !filtered;
    rights.priv_ok = secure && !sec_disable;
  end
endmodule

// File: rtl/pirq_bitmap.sv
module pirq_bitmap #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  input  logic [N-1:0] hw_set,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_v) | set_v | hw_set;
  end

  // R2
  bitmap_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_v != '0) |=> ((q & $past(set_v)) == $past(set_v)));

  // R2
  bitmap_clr_chk: assert property (@(posedge clk) disable iff (rst)
    ((clr_v & ~set_v & ~hw_set) != '0) |=> ((q & $past(clr_v & ~set_v & ~hw_set)) == '0));
endmodule

// File: rtl/pirq_line_edge.sv
module pirq_line_edge #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] level,
  input  logic [N-1:0] edge_cfg,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] lvl_pend_o
);
  logic [N-1:0] level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level;
  end

  always_comb begin
    rise_o     = level & ~level_q & edge_cfg;
    lvl_pend_o = level & ~edge_cfg;
  end

  // R6
  steady_line_chk: assert property (@(posedge clk) disable iff (rst)
    (level == $past(level)) |-> (rise_o == '0));
endmodule

// File: rtl/pirq_sgi_gate.sv
module pirq_sgi_gate #(
  parameter int unsigned N    = 32,
  parameter int unsigned NSGI = 16,
  localparam int unsigned IW  = $clog2(NSGI)
) (
  input  logic            req,
  input  logic [IW-1:0]   id,
  input  logic            grp1_req,
  input  logic            ns,
  input  logic            sec_disable,
  input  logic [NSGI-1:0] group,
  input  logic [2*NSGI-1:0] nsacc,
  output logic [N-1:0]    set_v
);
  logic       tgt_g1;
  logic [1:0] field;
  logic [1:0] need;
  logic       ok;

  always_comb begin
    tgt_g1 = group[id];
    field  = nsacc[{id, 1'b0} +: 2];
    need   = tgt_g1 ? 2'd2 : 2'd1;
    ok     = (grp1_req == tgt_g1) && (!ns || sec_disable || (field >= need));
    set_v  = '0;
    if (req && ok) set_v[id] = 1'b1;
  end
endmodule

// File: rtl/pirq_state_top.sv
module pirq_state_top #(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned NUM_SGI = 16,
  parameter int unsigned DW      = 32,
  localparam int unsigned AW     = pirq_pkg::REG_AW,
  localparam int unsigned HALF   = NUM_IRQ / 2,
  localparam int unsigned NSA_W  = 2 * NUM_SGI,
  localparam int unsigned SIW    = $clog2(NUM_SGI)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  input  logic               reg_secure,
  output logic [DW-1:0]      reg_rdata,
  input  logic               sec_disable,
  input  logic [NUM_IRQ-1:0] line_level,
  input  logic               sgi_req,
  input  logic [SIW-1:0]     sgi_id,
  input  logic               sgi_grp1,
  input  logic               sgi_ns,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic [NUM_IRQ-1:0] enable_o,
  output logic [NUM_IRQ-1:0] active_o,
  output logic [NUM_IRQ-1:0] group_o
);
  import pirq_pkg::*;

  logic [NUM_IRQ-1:0] group_q, edge_q, grpmod_q;
  logic [NSA_W-1:0]   nsacc_q;
  logic [NUM_IRQ-1:0] mask;
  acc_rights_t        rights;
  logic [NUM_IRQ-1:0] en_set, en_clr, pd_set, pd_clr, ac_set, ac_clr;
  logic [NUM_IRQ-1:0] rise, lvl_pend, sgi_set, pd_hw;
  logic [HALF-1:0]    cfg_wr_bits;
  logic [2*HALF-1:0]  cfg_a, cfg_b;
  logic [NUM_IRQ-1:0] edge_m;
  logic [DW-1:0]      rd_val;

  pirq_access_filter #(.N(NUM_IRQ)) filt_i (
    .secure(reg_secure), .sec_disable(sec_disable), .group(group_q),
    .mask(mask), .rights(rights));

  pirq_line_edge #(.N(NUM_IRQ)) line_i (
    .clk(clk), .rst(rst), .level(line_level), .edge_cfg(edge_q),
    .rise_o(rise), .lvl_pend_o(lvl_pend));

  pirq_sgi_gate #(.N(NUM_IRQ), .NSGI(NUM_SGI)) sgi_i (
    .req(sgi_req), .id(sgi_id), .grp1_req(sgi_grp1), .ns(sgi_ns),
    .sec_disable(sec_disable), .group(group_q[NUM_SGI-1:0]),
    .nsacc(nsacc_q), .set_v(sgi_set));

  // set/clear strobes, masked per bit by the access filter
  always_comb begin
    en_set = (reg_wr && reg_addr == A_EN_SET) ? reg_wdata[NUM_IRQ-1:0] & mask : '0;
    en_clr = (reg_wr && reg_addr == A_EN_CLR) ? reg_wdata[NUM_IRQ-1:0] & mask : '0;
    pd_set = (reg_wr && reg_addr == A_PD_SET) ? reg_wdata[NUM_IRQ-1:0] & mask : '0;
    pd_clr = (reg_wr && reg_addr == A_PD_CLR) ? reg_wdata[NUM_IRQ-1:0] & mask : '0;
    ac_set = (reg_wr && reg_addr == A_AC_SET) ? reg_wdata[NUM_IRQ-1:0] & mask : '0;
    ac_clr = (reg_wr && reg_addr == A_AC_CLR) ? reg_wdata[NUM_IRQ-1:0] & mask : '0;
    pd_hw  = rise | sgi_set;
  end

  pirq_bitmap #(.N(NUM_IRQ)) en_i (.clk(clk), .rst(rst), .set_v(en_set),
    .clr_v(en_clr), .hw_set('0), .q(enable_o));
  pirq_bitmap #(.N(NUM_IRQ)) pd_i (.clk(clk), .rst(rst), .set_v(pd_set),
    .clr_v(pd_clr), .hw_set(pd_hw), .q(pend_o));
  pirq_bitmap #(.N(NUM_IRQ)) ac_i (.clk(clk), .rst(rst), .set_v(ac_set),
    .clr_v(ac_clr), .hw_set('0), .q(active_o));

  // two-bit-per-interrupt packing of the trigger mode
  assign edge_m = edge_q & mask;
  for (genvar k = 0; k < HALF; k++) begin : g_cfg
    assign cfg_a[2*k]     = 1'b0;
    assign cfg_a[2*k+1]   = edge_m[k];
    assign cfg_b[2*k]     = 1'b0;
    assign cfg_b[2*k+1]   = edge_m[HALF+k];
    assign cfg_wr_bits[k] = reg_wdata[2*k+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      group_q  <= '0;
      edge_q   <= '0;
      grpmod_q <= '0;
      nsacc_q  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_GROUP && rights.grp_ok)  group_q  <= reg_wdata[NUM_IRQ-1:0];
      if (reg_addr == A_GRPMOD && rights.priv_ok) grpmod_q <= reg_wdata[NUM_IRQ-1:0];
      if (reg_addr == A_NSACC && rights.priv_ok)  nsacc_q  <= reg_wdata[NSA_W-1:0];
      if (reg_addr == A_CFG_B)
        edge_q[NUM_IRQ-1:HALF] <= (edge_q[NUM_IRQ-1:HALF] & ~mask[NUM_IRQ-1:HALF])
                                | (cfg_wr_bits & mask[NUM_IRQ-1:HALF]);
    end
  end

  always_comb begin
    rd_val = '0;
    case (reg_addr)
      A_GROUP:            rd_val = rights.grp_ok ? group_q : '0;
      A_EN_SET, A_EN_CLR: rd_val = enable_o & mask;
      A_PD_SET, A_PD_CLR: rd_val = (pend_o | lvl_pend) & mask;
      A_AC_SET, A_AC_CLR: rd_val = active_o & mask;
      A_CFG_A:            rd_val = cfg_a;
      A_CFG_B:            rd_val = cfg_b;
      A_GRPMOD:           rd_val = rights.priv_ok ? grpmod_q : '0;
      A_NSACC:            rd_val = rights.priv_ok ? nsacc_q : '0;
      default:            rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  assign group_o = group_q;

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));

  // R3
  ns_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!reg_secure && !sec_disable) |-> ((mask & ~group_q) == '0));

  // R6
  edge_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((pend_o & $past(rise)) == $past(rise)));

  // R9
  grpmod_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_GRPMOD && !(reg_secure && !sec_disable)) |=> $stable(grpmod_q));

  // R10
  sgi_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (sgi_req && sgi_ns && !sec_disable && nsacc_q[{sgi_id, 1'b0} +: 2] == 2'd0
     && !pend_o[sgi_id] && !reg_wr && rise[sgi_id] == 1'b0) |=> !pend_o[$past(sgi_id)]);

  // R8
  group_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_GROUP && !reg_secure && !sec_disable) |=> $stable(group_q));
endmodule

// File: tb/pirq_state_top_tb.sv
module pirq_state_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd, reg_secure, sec_disable;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, line_level;
  logic        sgi_req, sgi_grp1, sgi_ns;
  logic [3:0]  sgi_id;
  logic [31:0] pend_o, enable_o, active_o, group_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pirq_state_top dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_secure(reg_secure), .reg_rdata(reg_rdata),
    .sec_disable(sec_disable), .line_level(line_level), .sgi_req(sgi_req),
    .sgi_id(sgi_id), .sgi_grp1(sgi_grp1), .sgi_ns(sgi_ns), .pend_o(pend_o),
    .enable_o(enable_o), .active_o(active_o), .group_o(group_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic sec);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_secure = sec;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic sec, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a; reg_secure = sec;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic sgi(input logic [3:0] id, input logic g1, input logic ns);
    @(negedge clk);
    sgi_req = 1'b1; sgi_id = id; sgi_grp1 = g1; sgi_ns = ns;
    @(negedge clk);
    sgi_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pend", pend_o, 0);
    chk("R1 enable", enable_o, 0);
    chk("R1 active", active_o, 0);
    chk("R1 group", group_o, 0);
    chk("R1 rdata", reg_rdata, 0);
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    wr(4'd1, 32'hF0F0_00FF, 1'b1);
    chk("R2 set enable", enable_o, 32'hF0F0_00FF);
    wr(4'd2, 32'h0000_000F, 1'b1);
    chk("R2 clear enable", enable_o, 32'hF0F0_00F0);
    rd(4'd2, 1'b1, d);
    chk("R12 clear addr reads enable", d, 32'hF0F0_00F0);
    wr(4'd5, 32'h3, 1'b1);
    wr(4'd6, 32'h1, 1'b1);
    chk("R2 active set/clear", active_o, 32'h2);
    rd(4'd12, 1'b1, d);
    chk("R12 unlisted reads zero", d, 0);
  endtask

  task automatic t_nsfilter();
    logic [31:0] d;
    wr(4'd0, 32'h0000_FFFF, 1'b1);
    chk("R8 secure group write", group_o, 32'h0000_FFFF);
    wr(4'd1, 32'hFFFF_FFFF, 1'b0);
    chk("R3 ns set masked", enable_o, 32'hF0F0_FFFF);
    rd(4'd1, 1'b0, d);
    chk("R3 ns read masked", d, 32'h0000_FFFF);
    wr(4'd0, 32'h0, 1'b0);
    chk("R8 ns group write ignored", group_o, 32'h0000_FFFF);
    rd(4'd0, 1'b0, d);
    chk("R8 ns group reads zero", d, 0);
  endtask

  task automatic t_secdis();
    logic [31:0] d;
    sec_disable = 1'b1;
    wr(4'd2, 32'hFFFF_0000, 1'b0);
    chk("R4 ns clear unfiltered", enable_o, 32'h0000_FFFF);
    rd(4'd0, 1'b0, d);
    chk("R4 ns group readable", d, 32'h0000_FFFF);
    sec_disable = 1'b0;
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk); line_level[20] = 1'b1;
    @(negedge clk);
    chk("R5 level not latched", pend_o, 0);
    rd(4'd3, 1'b1, d);
    chk("R5 level merged on read", d, 32'h0010_0000);
    rd(4'd4, 1'b0, d);
    chk("R5 ns pending read masked", d, 0);
    @(negedge clk); line_level[20] = 1'b0;
    rd(4'd3, 1'b1, d);
    chk("R5 level gone", d, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wr(4'd8, 32'h0000_0201, 1'b1);
    rd(4'd8, 1'b1, d);
    chk("R7 word B irq20 at bit 9", d, 32'h0000_0200);
    wr(4'd7, 32'hFFFF_FFFF, 1'b1);
    rd(4'd7, 1'b1, d);
    chk("R7 word A write ignored", d, 0);
    wr(4'd8, 32'hAAAA_AAAA, 1'b0);
    rd(4'd8, 1'b1, d);
    chk("R7 ns word B write masked", d, 32'h0000_0200);
    rd(4'd8, 1'b0, d);
    chk("R3 ns word B read masked", d, 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    @(negedge clk); line_level[20] = 1'b1;
    @(negedge clk);
    chk("R6 rising edge latched", pend_o, 32'h0010_0000);
    wr(4'd4, 32'h0010_0000, 1'b1);
    repeat (3) @(negedge clk);
    chk("R6 held line no relatch", pend_o, 0);
    rd(4'd3, 1'b1, d);
    chk("R6 edge line not merged", d, 0);
    @(negedge clk); line_level[20] = 1'b0;
  endtask

  task automatic t_priv();
    logic [31:0] d;
    wr(4'd9, 32'h5, 1'b1);
    rd(4'd9, 1'b1, d);
    chk("R9 secure grpmod", d, 32'h5);
    rd(4'd9, 1'b0, d);
    chk("R9 ns grpmod zero", d, 0);
    wr(4'd9, 32'hFF, 1'b0);
    rd(4'd9, 1'b1, d);
    chk("R9 ns grpmod write ignored", d, 32'h5);
    sec_disable = 1'b1;
    rd(4'd9, 1'b1, d);
    chk("R9 grpmod zero when disabled", d, 0);
    wr(4'd9, 32'h3, 1'b1);
    sec_disable = 1'b0;
    rd(4'd9, 1'b1, d);
    chk("R9 disabled write ignored", d, 32'h5);
  endtask

  task automatic t_sgi();
    logic [31:0] d;
    wr(4'd0, 32'h0000_FF7F, 1'b1);
    wr(4'd10, 32'h0000_4840, 1'b1);
    rd(4'd10, 1'b1, d);
    chk("R9 access-level readback", d, 32'h0000_4840);
    sgi(4'd3, 1'b1, 1'b1);
    chk("R10 ns g1 level1 rejected", pend_o, 0);
    sgi(4'd4, 1'b1, 1'b1);
    chk("R10 ns level0 rejected", pend_o, 0);
    sgi(4'd5, 1'b1, 1'b1);
    chk("R10 ns g1 level2 accepted", pend_o, 32'h20);
    sgi(4'd7, 1'b0, 1'b1);
    chk("R10 ns g0 level1 accepted", pend_o, 32'hA0);
    sgi(4'd9, 1'b0, 1'b0);
    chk("R10 group mismatch rejected", pend_o, 32'hA0);
    sgi(4'd3, 1'b1, 1'b0);
    chk("R10 secure accepted", pend_o, 32'hA8);
  endtask

  task automatic t_timing();
    logic [31:0] d;
    rd(4'd1, 1'b1, d);
    chk("R11 read after one cycle", d, 32'h0000_FFFF);
    @(negedge clk); reg_addr = 4'd0;
    repeat (2) @(negedge clk);
    chk("R11 rdata holds", reg_rdata, 32'h0000_FFFF);
  endtask

  initial begin
    rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; reg_secure = 0;
    sec_disable = 0; line_level = 0; sgi_req = 0; sgi_id = 0; sgi_grp1 = 0; sgi_ns = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_setclr();
    t_nsfilter();
    t_secdis();
    t_level();
    t_cfg();
    t_edge();
    t_priv();
    t_sgi();
    t_timing();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule